// File: doc/BRIEF.md
# SDRAM Read Latency and Burst Return Pipeline

This block models how a single-data-rate SDRAM device returns read data. A mode-register load sets three things: the number of clocks between a READ and its first data word (two or three), the burst length, and the burst ordering. Each READ carries a starting column. The block places the read into a short delay line at the programmed depth. When the read leaves the delay line, the burst engine emits one word per clock from an internal data source that depends only on the column. The bus output enable comes on one clock before the first word is valid and goes off one clock after the last word.

A load that carries a reserved latency, burst-length or operating-mode code is refused. An error flag shows the refusal and the previous setting stays in force. A WRITE command opens a write-burst window, and the same programmed burst length sets its width. A newer READ or WRITE cuts short the burst in progress.

Top module: `sdram_rd_pipe`

## Requirements
- R1: After synchronous reset the latency is 3, the burst length is 1, the ordering is sequential and mode_err is 0. dq_oe, dq_valid and wr_burst are 0 and dq_out is 0.
- R2: A load is accepted only when bits 2:0 hold 0..3 (burst length 1, 2, 4 or 8), bits 6:4 hold 2 or 3 (latency) and bits 8:7 hold 00. Bit 3 selects interleaved ordering (1) or sequential ordering (0). The new setting shows on cas_lat and burst_len from the edge that registers the load.
- R3: Take a READ registered at edge n under latency m. dq_valid rises and the first word appears on dq_out at edge n+m.
- R4: For that READ, dq_oe rises at edge n+m-1, one edge before the first valid word.
- R5: The remaining words of the burst follow on consecutive edges, so dq_valid stays high for burst-length edges. dq_oe falls at the edge after the last word.
- R6: The word for column c is {~c, c}. Word i of a burst replaces the low log2(BL) bits of the start column with (start + i) mod BL in sequential ordering, or with start XOR i in interleaved ordering. The upper bits stay fixed.
- R7: A load with any reserved code leaves cas_lat, burst_len and the ordering unchanged. It sets mode_err from its registering edge until the next load, and an accepted load clears mode_err.
- R8: A newer READ cuts off the older burst. From the newer read's first-data edge onward only its words appear, and dq_oe stays high with no gap when the two bursts meet.
- R9: A WRITE registered at edge n drives wr_burst high after edges n through n+BL-1. A newer WRITE restarts the window.
- R10: A READ or WRITE registered at the same edge as a mode load uses the setting that was in force before that edge.
- R11: Outside read bursts dq_valid is low, dq_out is 0, and dq_oe is low except for the lead-in edge of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Load mode_word this cycle |
| mode_word | input | 9 | Latency, ordering, burst-length and operating-mode fields |
| rd_cmd | input | 1 | READ command |
| rd_col | input | COL_W | Start column of the READ |
| wr_cmd | input | 1 | WRITE command |
| dq_out | output | 2*COL_W | Read data bus value |
| dq_oe | output | 1 | Bus driver enable; low models high impedance |
| dq_valid | output | 1 | Data on dq_out is valid |
| wr_burst | output | 1 | Write-burst window |
| cas_lat | output | 2 | Latency in force |
| burst_len | output | 4 | Burst length in force (1, 2, 4, 8) |
| mode_err | output | 1 | Last load was refused |

## Verification
Two pairs of events can land on the same edge. The first is a mode load together with a READ or WRITE. The bench provokes it by issuing both on one edge, with the new latency and burst length different from the old ones. It passes only if the data and window timing follow the old setting. The second is a newer read's first word together with the tail of an older burst. Reads two or one cycles apart at latency 3, and mid-stream latency changes, create it. Every edge is compared against a schedule that the bench derives from the requirements, which cuts older entries off at the newer start.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;

  localparam int MODE_W  = 9;
  localparam int BLC_LSB = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int OP_LSB  = 7;

  typedef struct packed {
    logic [1:0] cl;
    logic       ilv;
    logic [1:0] bl_lg;
  } cfg_t;

  localparam cfg_t CFG_RST = '{cl: 2'd3, ilv: 1'b0, bl_lg: 2'd0};

  function automatic logic mode_legal(input logic [MODE_W-1:0] w);
    logic [2:0] blc;
    logic [2:0] clc;
    logic [1:0] op;
    blc = w[BLC_LSB +: 3];
    clc = w[CL_LSB +: 3];
    op  = w[OP_LSB +: 2];
    return (blc <= 3'd3) && ((clc == 3'd2) || (clc == 3'd3)) && (op == 2'b00);
  endfunction

  function automatic cfg_t mode_cfg(input logic [MODE_W-1:0] w);
    cfg_t c;
    c.cl    = w[CL_LSB +: 2];
    c.ilv   = w[BT_BIT];
    c.bl_lg = w[BLC_LSB +: 2];
    return c;
  endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [MODE_W-1:0] word,
  output cfg_t              cfg,
  output logic              err
);

  logic legal;
  assign legal = mode_legal(word);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CFG_RST;
      err <= 1'b0;
    end else if (load) begin
      err <= !legal;
      if (legal) cfg <= mode_cfg(word);
    end
  end

  // R7
  reserved_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !legal) |=> ($stable(cfg) && err));

  // R2
  cl_range_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.cl == 2'd2) || (cfg.cl == 2'd3));

endmodule

// File: rtl/sdram_lat_pipe.sv
module sdram_lat_pipe
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_cmd,
  input  logic [COL_W-1:0] rd_col,
  input  cfg_t             cfg,
  output logic             head_v_q,
  output logic             head_v_d,
  output logic [COL_W-1:0] head_col,
  output logic [1:0]       head_bl_lg,
  output logic             head_ilv
);

  logic             v_q   [MAX_CL];
  logic             v_d   [MAX_CL];
  logic [COL_W-1:0] col_q [MAX_CL];
  logic [COL_W-1:0] col_d [MAX_CL];
  logic [1:0]       bl_q  [MAX_CL];
  logic [1:0]       bl_d  [MAX_CL];
  logic             ilv_q [MAX_CL];
  logic             ilv_d [MAX_CL];

  int slot;
  assign slot = int'(cfg.cl) - 1;

  always_comb begin
    for (int k = 0; k < MAX_CL; k++) begin
      if (rd_cmd && (slot == k)) begin
        v_d[k]   = 1'b1;
        col_d[k] = rd_col;
        bl_d[k]  = cfg.bl_lg;
        ilv_d[k] = cfg.ilv;
      end else if (k < MAX_CL - 1) begin
        v_d[k]   = v_q[k+1];
        col_d[k] = col_q[k+1];
        bl_d[k]  = bl_q[k+1];
        ilv_d[k] = ilv_q[k+1];
      end else begin
        v_d[k]   = 1'b0;
        col_d[k] = '0;
        bl_d[k]  = '0;
        ilv_d[k] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < MAX_CL; k++) begin
      if (rst) begin
        v_q[k]   <= 1'b0;
        col_q[k] <= '0;
        bl_q[k]  <= '0;
        ilv_q[k] <= 1'b0;
      end else begin
        v_q[k]   <= v_d[k];
        col_q[k] <= col_d[k];
        bl_q[k]  <= bl_d[k];
        ilv_q[k] <= ilv_d[k];
      end
    end
  end

  assign head_v_q   = v_q[0];
  assign head_v_d   = v_d[0];
  assign head_col   = col_q[0];
  assign head_bl_lg = bl_q[0];
  assign head_ilv   = ilv_q[0];

  for (genvar k = 1; k < MAX_CL; k++) begin : g_slot_chk
    // R3
    slot_load_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_cmd && (int'(cfg.cl) == k + 1)) |=> v_q[k]);
  end

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen #(
  parameter int COL_W     = 8,
  parameter int MAX_BL_LG = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               head_v_q,
  input  logic               head_v_d,
  input  logic [COL_W-1:0]   head_col,
  input  logic [1:0]         head_bl_lg,
  input  logic               head_ilv,
  output logic [2*COL_W-1:0] dq_out,
  output logic               dq_valid,
  output logic               dq_oe
);

  localparam int DATA_W = 2 * COL_W;
  localparam int CNT_W  = MAX_BL_LG;

  logic [COL_W-1:0] base_q, base_d;
  logic [1:0]       bl_q, bl_d;
  logic             ilv_q, ilv_d;
  logic [CNT_W-1:0] idx_q, idx_d, rem_q, rem_d;
  logic [COL_W-1:0] col_d;
  logic             valid_d, oe_d;
  logic [DATA_W-1:0] data_d;

  function automatic logic [COL_W-1:0] burst_col(
    input logic [COL_W-1:0] base, input logic [CNT_W-1:0] idx,
    input logic [1:0] bl_lg, input logic ilv);
    logic [COL_W-1:0] mask, off, low;
    mask = COL_W'((32'd1 << bl_lg) - 32'd1);
    off  = COL_W'(idx);
    low  = ilv ? (base ^ off) : (base + off);
    return (base & ~mask) | (low & mask);
  endfunction

  always_comb begin
    base_d  = base_q;
    bl_d    = bl_q;
    ilv_d   = ilv_q;
    idx_d   = idx_q;
    rem_d   = '0;
    valid_d = 1'b0;
    col_d   = '0;
    if (head_v_q) begin
      base_d  = head_col;
      bl_d    = head_bl_lg;
      ilv_d   = head_ilv;
      idx_d   = '0;
      rem_d   = CNT_W'((32'd1 << head_bl_lg) - 32'd1);
      valid_d = 1'b1;
      col_d   = burst_col(head_col, '0, head_bl_lg, head_ilv);
    end else if (rem_q != '0) begin
      idx_d   = idx_q + 1'b1;
      rem_d   = rem_q - 1'b1;
      valid_d = 1'b1;
      col_d   = burst_col(base_q, idx_q + 1'b1, bl_q, ilv_q);
    end
    data_d = valid_d ? {~col_d, col_d} : '0;
    oe_d   = valid_d | head_v_d | (rem_d != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      bl_q     <= '0;
      ilv_q    <= 1'b0;
      idx_q    <= '0;
      rem_q    <= '0;
      dq_out   <= '0;
      dq_valid <= 1'b0;
      dq_oe    <= 1'b0;
    end else begin
      base_q   <= base_d;
      bl_q     <= bl_d;
      ilv_q    <= ilv_d;
      idx_q    <= idx_d;
      rem_q    <= rem_d;
      dq_out   <= data_d;
      dq_valid <= valid_d;
      dq_oe    <= oe_d;
    end
  end

  // R4
  oe_lead_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_valid) |-> $past(dq_oe));

  // R3
  head_issue_chk: assert property (@(posedge clk) disable iff (rst)
    head_v_q |=> dq_valid);

  // R5
  burst_run_chk: assert property (@(posedge clk) disable iff (rst)
    (rem_q != '0) |=> (dq_valid && dq_oe));

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_valid |-> (dq_out == '0));

endmodule

// File: rtl/sdram_wr_window.sv
module sdram_wr_window #(
  parameter int MAX_BL_LG = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_cmd,
  input  logic [1:0] bl_lg,
  output logic       wr_burst
);

  localparam int CNT_W = MAX_BL_LG;

  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q    <= '0;
      wr_burst <= 1'b0;
    end else if (wr_cmd) begin
      rem_q    <= CNT_W'((32'd1 << bl_lg) - 32'd1);
      wr_burst <= 1'b1;
    end else if (rem_q != '0) begin
      rem_q    <= rem_q - 1'b1;
      wr_burst <= 1'b1;
    end else begin
      wr_burst <= 1'b0;
    end
  end

  // R9
  wr_start_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> wr_burst);

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
  import sdram_rd_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MAX_CL = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_load,
  input  logic [8:0]         mode_word,
  input  logic               rd_cmd,
  input  logic [COL_W-1:0]   rd_col,
  input  logic               wr_cmd,
  output logic [2*COL_W-1:0] dq_out,
  output logic               dq_oe,
  output logic               dq_valid,
  output logic               wr_burst,
  output logic [1:0]         cas_lat,
  output logic [3:0]         burst_len,
  output logic               mode_err
);

  localparam int MAX_BL_LG = 3;

  cfg_t             cfg;
  logic             head_v_q, head_v_d, head_ilv;
  logic [COL_W-1:0] head_col;
  logic [1:0]       head_bl_lg;

  sdram_mode_reg u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (mode_load),
    .word (mode_word),
    .cfg  (cfg),
    .err  (mode_err)
  );

  sdram_lat_pipe #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .rd_cmd     (rd_cmd),
    .rd_col     (rd_col),
    .cfg        (cfg),
    .head_v_q   (head_v_q),
    .head_v_d   (head_v_d),
    .head_col   (head_col),
    .head_bl_lg (head_bl_lg),
    .head_ilv   (head_ilv)
  );

  sdram_burst_gen #(.COL_W(COL_W), .MAX_BL_LG(MAX_BL_LG)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .head_v_q   (head_v_q),
    .head_v_d   (head_v_d),
    .head_col   (head_col),
    .head_bl_lg (head_bl_lg),
    .head_ilv   (head_ilv),
    .dq_out     (dq_out),
    .dq_valid   (dq_valid),
    .dq_oe      (dq_oe)
  );

  sdram_wr_window #(.MAX_BL_LG(MAX_BL_LG)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .wr_cmd   (wr_cmd),
    .bl_lg    (cfg.bl_lg),
    .wr_burst (wr_burst)
  );

  assign cas_lat   = cfg.cl;
  assign burst_len = 4'(4'd1 << cfg.bl_lg);

endmodule

// File: tb/sim_sdram_rd_pipe.sv
`timescale 1ns/1ps
module sim_sdram_rd_pipe;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_load = 1'b0;
  logic [8:0]  mode_word = '0;
  logic        rd_cmd = 1'b0;
  logic [7:0]  rd_col = '0;
  logic        wr_cmd = 1'b0;
  logic [15:0] dq_out;
  logic        dq_oe, dq_valid, wr_burst, mode_err;
  logic [1:0]  cas_lat;
  logic [3:0]  burst_len;

  int n_cmp = 0;
  int n_bad = 0;
  int t = 0;
  bit done = 0;

  int  b_cl = 3, b_blg = 0, b_err = 0;
  bit  b_ilv = 0;
  bit          ev [64];
  logic [15:0] ed [64];
  bit          ew [64];

  always #4 clk = ~clk;

  sdram_rd_pipe u0 (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_word(mode_word),
    .rd_cmd(rd_cmd), .rd_col(rd_col), .wr_cmd(wr_cmd),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_valid(dq_valid), .wr_burst(wr_burst),
    .cas_lat(cas_lat), .burst_len(burst_len), .mode_err(mode_err)
  );

  function automatic logic [8:0] mw(int cl, int blc, int ilv, int op);
    return {2'(op), 3'(cl), 1'(ilv), 3'(blc)};
  endfunction

  function automatic int ref_col(int base, int i, int blg, bit ilv);
    int blen = 1 << blg;
    int lb = base % blen;
    int low = ilv ? (lb ^ i) : ((lb + i) % blen);
    return base - lb + low;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, t, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    int s = t % 64;
    int s1 = (t + 1) % 64;
    chk({tag, " R3"}, "dq_valid", int'(dq_valid), int'(ev[s]));
    chk({tag, " R6 R11"}, "dq_out", int'(dq_out), ev[s] ? int'(ed[s]) : 0);
    chk({tag, " R4 R5"}, "dq_oe", int'(dq_oe), int'(ev[s] | ev[s1]));
    chk({tag, " R9"}, "wr_burst", int'(wr_burst), int'(ew[s]));
    chk({tag, " R2"}, "cas_lat", int'(cas_lat), b_cl);
    chk({tag, " R2"}, "burst_len", int'(burst_len), 1 << b_blg);
    chk({tag, " R7"}, "mode_err", int'(mode_err), b_err);
    ev[s] = 0; ed[s] = '0; ew[s] = 0;
  endtask

  // one clock: inputs applied now, model updated, outputs compared after the edge
  task automatic cycle(bit rd, int col, bit wr, bit ld, logic [8:0] word, string tag);
    int n = t + 1;
    rd_cmd = rd; rd_col = 8'(col); wr_cmd = wr; mode_load = ld; mode_word = word;
    if (rd) begin
      int st = n + b_cl;
      for (int k = st; k < st + 9; k++) ev[k % 64] = 0;
      for (int i = 0; i < (1 << b_blg); i++) begin
        int c = ref_col(col & 255, i, b_blg, b_ilv);
        ev[(st + i) % 64] = 1;
        ed[(st + i) % 64] = {8'(~c), 8'(c)};
      end
    end
    if (wr) begin
      for (int k = n; k < n + 9; k++) ew[k % 64] = 0;
      for (int i = 0; i < (1 << b_blg); i++) ew[(n + i) % 64] = 1;
    end
    if (ld) begin
      bit ok = (word[2:0] < 3'd4) && (word[6:4] == 3'd2 || word[6:4] == 3'd3) && (word[8:7] == 2'b00);
      b_err = ok ? 0 : 1;
      if (ok) begin b_cl = int'(word[6:4]); b_blg = int'(word[1:0]); b_ilv = word[3]; end
    end
    @(posedge clk);
    t++;
    @(negedge clk);
    rd_cmd = 0; wr_cmd = 0; mode_load = 0;
    compare_all(tag);
  endtask

  task automatic idle(int k, string tag);
    for (int i = 0; i < k; i++) cycle(0, 0, 0, 0, '0, tag);
  endtask

  initial begin
    #1600000;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", t);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t = 0;
    // R1 reset state
    chk("R1", "cas_lat", int'(cas_lat), 3);
    chk("R1", "burst_len", int'(burst_len), 1);
    chk("R1", "mode_err", int'(mode_err), 0);
    chk("R1", "dq_oe", int'(dq_oe), 0);
    chk("R1", "dq_valid", int'(dq_valid), 0);
    chk("R1", "dq_out", int'(dq_out), 0);
    chk("R1", "wr_burst", int'(wr_burst), 0);

    // R3 R4 default latency 3, single word
    cycle(1, 8'h21, 0, 0, '0, "R3");
    idle(6, "R11");
    // R2 latency 2, burst 1
    cycle(0, 0, 0, 1, mw(2, 0, 0, 0), "R2");
    cycle(1, 8'h10, 0, 0, '0, "R3");
    idle(5, "R4");
    // R5 latency 3, burst 4 sequential
    cycle(0, 0, 0, 1, mw(3, 2, 0, 0), "R2");
    cycle(1, 8'h46, 0, 0, '0, "R5");
    idle(9, "R5");
    // R6 burst 8 sequential, then interleaved
    cycle(0, 0, 0, 1, mw(2, 3, 0, 0), "R2");
    cycle(1, 8'h35, 0, 0, '0, "R6");
    idle(11, "R6");
    cycle(0, 0, 0, 1, mw(2, 3, 1, 0), "R2");
    cycle(1, 8'h35, 0, 0, '0, "R6");
    idle(11, "R6");
    // R8 truncation at latency 3 burst 8: two apart, then back to back
    cycle(0, 0, 0, 1, mw(3, 3, 0, 0), "R2");
    cycle(1, 8'h80, 0, 0, '0, "R8");
    idle(1, "R8");
    cycle(1, 8'hC4, 0, 0, '0, "R8");
    cycle(1, 8'h0F, 0, 0, '0, "R8");
    idle(13, "R8");
    // R7 reserved codes: latency 4, op mode 01, burst code 5, latency 1
    cycle(0, 0, 0, 1, mw(4, 1, 0, 0), "R7");
    cycle(1, 8'h12, 0, 0, '0, "R7");
    idle(12, "R7");
    cycle(0, 0, 0, 1, mw(2, 1, 0, 1), "R7");
    cycle(0, 0, 0, 1, mw(2, 5, 0, 0), "R7");
    cycle(0, 0, 0, 1, mw(1, 0, 0, 0), "R7");
    idle(2, "R7");
    cycle(0, 0, 0, 1, mw(3, 1, 0, 0), "R7");
    // R10 load together with read and write
    cycle(1, 8'h5A, 1, 1, mw(2, 2, 1, 0), "R10");
    idle(8, "R10");
    cycle(1, 8'h5A, 1, 1, mw(3, 0, 0, 0), "R10");
    idle(8, "R10");
    // R9 write window and restart
    cycle(0, 0, 0, 1, mw(2, 2, 0, 0), "R2");
    cycle(0, 0, 1, 0, '0, "R9");
    idle(1, "R9");
    cycle(0, 0, 1, 0, '0, "R9");
    idle(6, "R9");

    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      bit rd = ($urandom % 100) < 30;
      bit wr = ($urandom % 100) < 20;
      bit ld = ($urandom % 100) < 6;
      int col = int'($urandom % 256);
      logic [8:0] w;
      if (($urandom % 4) == 0) w = 9'($urandom);
      else w = mw(2 + int'($urandom % 2), int'($urandom % 4), int'($urandom % 2), 0);
      cycle(rd, col, wr, ld, w, "R8 R10");
    end
    idle(14, "R11");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule